// File: doc/BRIEF.md
# Transmitter PHY power-up sequencer

This block brings the analog section of a display transmitter PHY out of power-down. After a start pulse it walks seven power-down controls through five fixed steps. Each later step releases more of the PHY, and timed waits sit between the steps. The second step is not a plain register write. The block asks a power-management unit to release the pads from deep power-down and waits for that unit to report that the release happened. The rest of the sequence runs only if this handshake succeeds.

A start is a no-op when the PHY is already up. This is the case when an earlier run of this block finished, or when a lane-0 status input shows that other logic already powered the pads. The block then reports done and already-up on the next cycle. If the power-management unit never confirms the release, the block stops with an error pulse. All timing is expressed in microseconds and scaled by a cycles-per-microsecond parameter.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset, `pd_ctl` is 7'h7F. `pmu_sample_en`, `pmu_timer_val`, `pmu_req_lvds` and `pmu_req_code` are all zero. `busy`, `done`, `already_up`, `err` and `powered` are all zero.
- R2: The bit order of `pd_ctl` is [6] port, [5] PLL, [4] bandgap, [3] VCO, [2] PLL capacitor, [1] I/O deep power-down, [0] calibration. A start is accepted when the block is idle, `powered` is low and `lane0_up` is low. On the edge that samples an accepted start, `pd_ctl` becomes 7'h7F, `pmu_sample_en` rises, `pmu_timer_val` becomes 10 and `busy` rises. On the next edge, `pmu_req_lvds` rises and `pmu_req_code` becomes 2'b01. The request code values are 00 for idle, 01 for deep power-down off and 10 for deep power-down on.
- R3: The status input `pmu_lvds_on_stat` is sampled every 20 us, measured from the edge that raised the request. At the first sample that is low, bit 1 of `pd_ctl` clears and `pmu_sample_en` falls on that same edge.
- R4: Bit 4 clears 15 us after bit 1 clears. Bits 5, 3 and 2 clear 25 us after that. Bit 6 clears 225 us after that, on the same edge where `done` pulses for one cycle and `busy` falls. Bit 0 stays at 1 throughout.
- R5: If the status is still high at the 500th sample (10 ms), `err` pulses for one cycle and the block returns to idle. `pd_ctl` stays 7'h7F, and the sample enable and request outputs keep their values.
- R6: A start while idle with `powered` or `lane0_up` high causes `done` and `already_up` to pulse together on the next edge. No other output changes.
- R7: A start while `busy` is high has no effect on any output.
- R8: `powered` rises with the `done` pulse of a full sequence and stays high until reset. An error leaves it low, and a later start runs the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse |
| lane0_up | input | 1 | Lane 0 already out of power-down |
| pmu_lvds_on_stat | input | 1 | Power-management status: pads still held in deep power-down |
| pd_ctl | output | 7 | Power-down controls (bit order in R2) |
| pmu_sample_en | output | 1 | Sample enable to the power-management unit |
| pmu_timer_val | output | TIMER_W | Deep power-down timer value |
| pmu_req_lvds | output | 1 | LVDS pad request |
| pmu_req_code | output | 2 | Request code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| already_up | output | 1 | One-cycle pulse: start skipped because the PHY is up |
| err | output | 1 | One-cycle handshake timeout pulse |
| powered | output | 1 | Sticky powered-up flag |

## Verification
The hardest cases to reach are at the edges of the handshake timeout. One is a status that stays high through all 500 samples. The other is a status that drops just before the final sample, which must still count as success. The bench keeps the status high for an exact number of 20 us intervals and lowers it halfway between the 499th and 500th samples. A bench-side timeline model predicts every output on every cycle. Another run holds the status high forever, then starts again to show that the error left the block unpowered.

// File: rtl/pwrseq_pkg.sv
// Shared constants and state types for the PHY power-up sequencer.
// Assumes pd_ctl bit positions are fixed by the PHY wiring.
package pwrseq_pkg;
    localparam int PD_PORT = 6;
    localparam int PD_PLL  = 5;
    localparam int PD_BG   = 4;
    localparam int PD_VCO  = 3;
    localparam int PD_CAP  = 2;
    localparam int PD_IO   = 1;
    localparam logic [6:0] PD_ALL = 7'h7F;

    localparam logic [1:0] REQ_IDLE    = 2'd0;
    localparam logic [1:0] REQ_DPD_OFF = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HS, ST_W_BG, ST_W_PLL, ST_W_PORT
    } seq_state_t;

    typedef enum logic [1:0] {
        HS_IDLE, HS_REQ, HS_POLL
    } hs_state_t;
endpackage

// File: rtl/pwrseq_tick_cnt.sv
// Interval counter: hit pulses every 'limit' cycles while clr is low.
// Assumes limit >= 1; clr holds the count at zero.
module pwrseq_tick_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = !clr && (cnt == limit - W'(1));

    // Count up, wrapping on hit, held at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || hit) cnt <= '0;
        else                      cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/pwrseq_dpd_hs.sv
// Deep power-down release handshake with the power-management unit.
// Sets sample enable and timer, raises the request one cycle later, then
// samples the status every POLL_US. Signals ok on the first low sample and
// fail when the status is still high at the last sample. Assumes go only
// arrives while the handshake is idle.
module pwrseq_dpd_hs
    import pwrseq_pkg::*;
#(
    parameter int CYC_PER_US = 4,
    parameter int POLL_US    = 20,
    parameter int TIMEOUT_US = 10000,
    parameter int TIMER_W    = 8,
    parameter int TIMER_VAL  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic               lvds_on_stat,
    output logic               sample_en,
    output logic [TIMER_W-1:0] timer_val,
    output logic               req_lvds,
    output logic [1:0]         req_code,
    output logic               ok,
    output logic               fail
);
    localparam int POLL_CYC = POLL_US * CYC_PER_US;
    localparam int N_POLL   = TIMEOUT_US / POLL_US;
    localparam int PC_W     = $clog2(POLL_CYC + 1);
    localparam int NP_W     = $clog2(N_POLL + 1);

    hs_state_t     hst;
    logic          tick;
    logic          last;
    logic [NP_W-1:0] polls;

    pwrseq_tick_cnt #(.W(PC_W)) u_poll_tmr (
        .clk(clk), .rst_n(rst_n), .clr(hst != HS_POLL),
        .limit(PC_W'(POLL_CYC)), .hit(tick)
    );

    assign last = (polls == NP_W'(N_POLL - 1));
    assign ok   = (hst == HS_POLL) && tick && !lvds_on_stat;
    assign fail = (hst == HS_POLL) && tick && lvds_on_stat && last;

    // Handshake state and register outputs toward the power-management unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst       <= HS_IDLE;
            sample_en <= 1'b0;
            timer_val <= '0;
            req_lvds  <= 1'b0;
            req_code  <= REQ_IDLE;
            polls     <= '0;
        end else begin
            case (hst)
                HS_IDLE: if (go) begin
                    sample_en <= 1'b1;
                    timer_val <= TIMER_W'(TIMER_VAL);
                    hst       <= HS_REQ;
                end
                HS_REQ: begin
                    req_lvds <= 1'b1;
                    req_code <= REQ_DPD_OFF;
                    polls    <= '0;
                    hst      <= HS_POLL;
                end
                HS_POLL: if (tick) begin
                    if (ok) begin
                        sample_en <= 1'b0;
                        hst       <= HS_IDLE;
                    end else if (last) begin
                        hst <= HS_IDLE;
                    end else begin
                        polls <= polls + NP_W'(1);
                    end
                end
                default: hst <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_pwrup_seq.sv
// PHY power-up sequencer top. Steps the seven power-down controls through
// the fixed release order, with the deep power-down handshake as step 2 and
// timed waits after steps 2, 3 and 4. Assumes start is a single-cycle pulse
// and lane0_up is synchronous to clk.
module phy_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int CYC_PER_US = 4,
    parameter int POLL_US    = 20,
    parameter int TIMEOUT_US = 10000,
    parameter int W_BG_US    = 15,
    parameter int W_PLL_US   = 25,
    parameter int W_PORT_US  = 225,
    parameter int TIMER_W    = 8,
    parameter int TIMER_VAL  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               lane0_up,
    input  logic               pmu_lvds_on_stat,
    output logic [6:0]         pd_ctl,
    output logic               pmu_sample_en,
    output logic [TIMER_W-1:0] pmu_timer_val,
    output logic               pmu_req_lvds,
    output logic [1:0]         pmu_req_code,
    output logic               busy,
    output logic               done,
    output logic               already_up,
    output logic               err,
    output logic               powered
);
    localparam int BG_CYC   = W_BG_US * CYC_PER_US;
    localparam int PLL_CYC  = W_PLL_US * CYC_PER_US;
    localparam int PORT_CYC = W_PORT_US * CYC_PER_US;
    localparam int WAIT_W   = $clog2(PORT_CYC + 1);

    seq_state_t      st;
    logic            accept, shortcut, in_wait;
    logic            hs_ok, hs_fail, wait_hit;
    logic [WAIT_W-1:0] wait_lim;

    assign busy     = (st != ST_IDLE);
    assign accept   = (st == ST_IDLE) && start && !powered && !lane0_up;
    assign shortcut = (st == ST_IDLE) && start && (powered || lane0_up);
    assign in_wait  = (st == ST_W_BG) || (st == ST_W_PLL) || (st == ST_W_PORT);

    // Select the wait length for the current step.
    always_comb begin
        case (st)
            ST_W_BG:  wait_lim = WAIT_W'(BG_CYC);
            ST_W_PLL: wait_lim = WAIT_W'(PLL_CYC);
            default:  wait_lim = WAIT_W'(PORT_CYC);
        endcase
    end

    pwrseq_tick_cnt #(.W(WAIT_W)) u_step_tmr (
        .clk(clk), .rst_n(rst_n), .clr(!in_wait),
        .limit(wait_lim), .hit(wait_hit)
    );

    pwrseq_dpd_hs #(
        .CYC_PER_US(CYC_PER_US), .POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US),
        .TIMER_W(TIMER_W), .TIMER_VAL(TIMER_VAL)
    ) u_hs (
        .clk(clk), .rst_n(rst_n), .go(accept), .lvds_on_stat(pmu_lvds_on_stat),
        .sample_en(pmu_sample_en), .timer_val(pmu_timer_val),
        .req_lvds(pmu_req_lvds), .req_code(pmu_req_code),
        .ok(hs_ok), .fail(hs_fail)
    );

    // Step sequencing, power-down control pattern and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            pd_ctl     <= PD_ALL;
            done       <= 1'b0;
            already_up <= 1'b0;
            err        <= 1'b0;
            powered    <= 1'b0;
        end else begin
            done       <= 1'b0;
            already_up <= 1'b0;
            err        <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (shortcut) begin
                        done       <= 1'b1;
                        already_up <= 1'b1;
                    end
                    if (accept) begin
                        pd_ctl <= PD_ALL;
                        st     <= ST_HS;
                    end
                end
                ST_HS: begin
                    if (hs_ok) begin
                        pd_ctl[PD_IO] <= 1'b0;
                        st            <= ST_W_BG;
                    end else if (hs_fail) begin
                        err <= 1'b1;
                        st  <= ST_IDLE;
                    end
                end
                ST_W_BG: if (wait_hit) begin
                    pd_ctl[PD_BG] <= 1'b0;
                    st            <= ST_W_PLL;
                end
                ST_W_PLL: if (wait_hit) begin
                    pd_ctl[PD_PLL] <= 1'b0;
                    pd_ctl[PD_VCO] <= 1'b0;
                    pd_ctl[PD_CAP] <= 1'b0;
                    st             <= ST_W_PORT;
                end
                ST_W_PORT: if (wait_hit) begin
                    pd_ctl[PD_PORT] <= 1'b0;
                    done            <= 1'b1;
                    powered         <= 1'b1;
                    st              <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_pwrup_seq_chk.sv
// Property checker for the PHY power-up sequencer, bound to the top.
module phy_pwrup_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       lane0_up,
    input logic       pmu_lvds_on_stat,
    input logic [6:0] pd_ctl,
    input logic       pmu_sample_en,
    input logic       busy,
    input logic       done,
    input logic       already_up,
    input logic       err,
    input logic       powered
);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !powered && !lane0_up) |=>
        (pd_ctl == 7'h7F && pmu_sample_en && busy));

    // R3
    io_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_ctl[1]) |-> (!pmu_sample_en && !$past(pmu_lvds_on_stat)));

    // R4
    finish_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !already_up) |-> (pd_ctl == 7'h01 && powered && !busy));

    // R5
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (pd_ctl == 7'h7F && !busy && !powered && !done));

    // R6
    shortcut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (powered || lane0_up)) |=>
        (done && already_up && !busy && $stable(pd_ctl)));

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        powered |=> powered);
endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .lane0_up(lane0_up),
    .pmu_lvds_on_stat(pmu_lvds_on_stat), .pd_ctl(pd_ctl),
    .pmu_sample_en(pmu_sample_en), .busy(busy), .done(done),
    .already_up(already_up), .err(err), .powered(powered)
);

// File: tb/test_phy_pwrup_seq.sv
`timescale 1ns/1ps
module test_phy_pwrup_seq;
    localparam int CPU  = 2;
    localparam int P    = 20 * CPU;
    localparam int NP   = 500;
    localparam int WBG  = 15 * CPU;
    localparam int WPLL = 25 * CPU;
    localparam int WPRT = 225 * CPU;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, lane0_up = 1'b0, stat = 1'b1;
    logic [6:0] pd_ctl;
    logic       samp, req, busy, done, already, err, powered;
    logic [7:0] tval;
    logic [1:0] code;

    always #2 clk = ~clk;

    phy_pwrup_seq #(.CYC_PER_US(CPU)) i_phy_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lane0_up(lane0_up),
        .pmu_lvds_on_stat(stat), .pd_ctl(pd_ctl), .pmu_sample_en(samp),
        .pmu_timer_val(tval), .pmu_req_lvds(req), .pmu_req_code(code),
        .busy(busy), .done(done), .already_up(already), .err(err),
        .powered(powered)
    );

    int vectors = 0, bad = 0;
    bit live = 0, ended = 0;

    // Timeline reference model: phase plus absolute-cycle deadlines.
    int cyc = 0, phase = 0, deadline = 0, npoll = 0;
    logic [6:0] e_pd;
    logic e_samp, e_req, e_done, e_alr, e_err, e_pow;
    logic [7:0] e_tval;
    logic [1:0] e_code;

    always @(posedge clk) begin
        cyc++;
        live = 1;
        e_done = 0; e_alr = 0; e_err = 0;
        if (!rst_n) begin
            phase = 0; e_pd = 7'h7F; e_samp = 0; e_tval = 0; e_req = 0;
            e_code = 0; e_pow = 0;
        end else begin
            case (phase)
                0: if (start) begin
                    if (e_pow || lane0_up) begin e_done = 1; e_alr = 1; end
                    else begin e_pd = 7'h7F; e_samp = 1; e_tval = 10; phase = 1; end
                end
                1: begin e_req = 1; e_code = 2'b01; phase = 2; deadline = cyc + P; npoll = 1; end
                2: if (cyc == deadline) begin
                    if (!stat) begin
                        e_pd[1] = 0; e_samp = 0; phase = 3; deadline = cyc + WBG;
                    end else if (npoll == NP) begin
                        e_err = 1; phase = 0;
                    end else begin
                        npoll++; deadline = cyc + P;
                    end
                end
                3: if (cyc == deadline) begin e_pd[4] = 0; phase = 4; deadline = cyc + WPLL; end
                4: if (cyc == deadline) begin
                    e_pd[5] = 0; e_pd[3] = 0; e_pd[2] = 0; phase = 5; deadline = cyc + WPRT;
                end
                default: if (cyc == deadline) begin
                    e_pd[6] = 0; e_done = 1; e_pow = 1; phase = 0;
                end
            endcase
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) if (live && !ended) begin
        cmp("R4", "pd_ctl", int'(pd_ctl), int'(e_pd));
        cmp("R3", "sample_en", int'(samp), int'(e_samp));
        cmp("R2", "timer_val", int'(tval), int'(e_tval));
        cmp("R2", "req_lvds", int'(req), int'(e_req));
        cmp("R2", "req_code", int'(code), int'(e_code));
        cmp("R7", "busy", int'(busy), int'(phase != 0));
        cmp("R4", "done", int'(done), int'(e_done));
        cmp("R6", "already_up", int'(already), int'(e_alr));
        cmp("R5", "err", int'(err), int'(e_err));
        cmp("R8", "powered", int'(powered), int'(e_pow));
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        wait_n(3); rst_n = 1;
    endtask

    task automatic finish_run();
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state
        cmp("R1", "reset pd_ctl", int'(pd_ctl), 'h7F);
        cmp("R1", "reset outputs", int'({samp, tval, req, code, busy, done, already, err, powered}), 0);

        // R2 R3 R4: status clears at the third poll; R7: start mid-run ignored
        stat = 1;
        pulse_start();
        wait_n(2 * P + P / 2); stat = 0;
        wait_n(P + 10); pulse_start();   // R7
        wait_n(WBG + WPLL + WPRT + 20);
        cmp("R4", "powered after run", int'(powered), 1);
        cmp("R4", "final pd_ctl", int'(pd_ctl), 'h01);

        // R6 R8: start when powered is skipped
        pulse_start();
        wait_n(5);
        cmp("R8", "powered sticky", int'(powered), 1);

        // R6: lane0_up skip after reset
        do_reset();
        lane0_up = 1; pulse_start(); wait_n(3); lane0_up = 0;
        cmp("R6", "pd unchanged", int'(pd_ctl), 'h7F);

        // R5: status never clears
        stat = 1;
        pulse_start();
        wait_n(NP * P + 20);
        cmp("R5", "pd after timeout", int'(pd_ctl), 'h7F);
        cmp("R5", "sample held", int'(samp), 1);
        cmp("R8", "not powered after error", int'(powered), 0);

        // R5 R3: status drops just before the last permitted poll
        pulse_start();
        wait_n((NP - 1) * P + P / 2); stat = 0;
        wait_n(P + WBG + WPLL + WPRT + 20);
        cmp("R5", "success at last poll", int'(powered), 1);

        // R3: immediate release at first poll after reset
        do_reset();
        stat = 0; pulse_start();
        wait_n(P + WBG + WPLL + WPRT + 20);
        cmp("R3", "first-poll release", int'(pd_ctl), 'h01);
        finish_run();
    end
endmodule